// File: doc/BRIEF.md
# Fault-Hardened Sequencing Controller

This block is the top-level control state machine of a security peripheral. It is built so that an injected fault cannot quietly change its behaviour. The host enables it, sets a step target and sends strobes. The first strobe starts a run. Each later strobe advances a step counter. When the counter reaches the target, the controller reports completion. A small front-end handshake machine turns each strobe into one step request, however long the strobe stays high.

Each state register uses a sparse 6-bit encoding in which any two legal codes differ in at least three bits. Both machines check their state code on every cycle. The step counter is kept twice: once as its true value and once as a bitwise complement, and the two copies are compared continuously. Any of these faults sets its own sticky error bit. It also sends both machines into absorbing error states and raises a fatal alert, and only reset clears it.

Top module: `hfsm_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fatal_alert_o` are 0 and `err_code_o` is 3'b000.
- R2: A strobe taken while `enable_i` is 1 and the controller is idle starts a run and clears the counter. With `target_i` nonzero, `busy_o` rises. With `target_i` zero, `done_o` rises at once.
- R3: During a run, each strobe increments the counter. After exactly `target_i` strobes following the start strobe, `busy_o` falls and `done_o` rises. `target_i` is held steady during a run.
- R4: A strobe held high for many cycles produces one step. A new step needs the strobe to go low and high again.
- R5: A strobe while done returns the controller to idle. `enable_i` low for one clock edge returns it to idle from running or done.
- R6: While idle with `enable_i` low, strobes have no effect: `busy_o` and `done_o` stay 0.
- R7: The main state codes are idle 6'b101100, run 6'b010110, done 6'b111011 and error 6'b000001. Any other value in the main state register sets `err_code_o[0]` and enters the error state at the next edge.
- R8: The strobe-handshake state codes are idle 6'b011001, pulse 6'b100011, wait 6'b110100 and error 6'b001110. Any other value in that register sets `err_code_o[1]` and also sends the main machine to the error state.
- R9: The counter copy is stored as the bitwise complement of the counter. If the bitwise XOR of the two copies is not all ones, `err_code_o[2]` is set and the main machine enters the error state.
- R10: The error state is absorbing. `fatal_alert_o` stays 1 and `busy_o`/`done_o` stay 0 whatever the inputs do, until reset.
- R11: Error bits are sticky until reset. Whenever any error bit is 1, `fatal_alert_o` is 1.
- R12: `busy_o` and `done_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Controller enable |
| strobe_i | input | 1 | Start/step strobe, acted on when it goes high |
| target_i | input | CNT_W | Number of steps after the start strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Target reached |
| err_code_o | output | 3 | Sticky fault bits: [0] main state, [1] handshake state, [2] counter pair |
| fatal_alert_o | output | 1 | Fatal alert, held in the error state |

## Verification
The fault paths cannot be reached from the ports of a correct design. No input sequence produces an illegal state code or makes the counter copies disagree. The bench therefore uses a one-shot `force`/`release` on the state register or the primary counter at a falling edge. The register keeps the corrupted value until the next clock edge re-evaluates it. This is the way a glitch would hit a flop, and it leaves the design's own logic to detect and escalate the fault. Each injection is followed by strobes and enable changes, to show that the error state absorbs them until reset.

// File: rtl/hfsm_pkg.sv
// Package: shared sparse state codes and legality checks for the hardened controller.
// Assumes 6-bit state registers; every legal pair differs in 4 bits.
package hfsm_pkg;
    localparam int unsigned STATE_W = 6;
    localparam int unsigned ERR_W   = 3;

    // Main sequencing machine codes
    localparam logic [STATE_W-1:0] M_IDLE = 6'b101100;
    localparam logic [STATE_W-1:0] M_RUN  = 6'b010110;
    localparam logic [STATE_W-1:0] M_DONE = 6'b111011;
    localparam logic [STATE_W-1:0] M_ERR  = 6'b000001;

    // Strobe handshake machine codes
    localparam logic [STATE_W-1:0] A_IDLE  = 6'b011001;
    localparam logic [STATE_W-1:0] A_PULSE = 6'b100011;
    localparam logic [STATE_W-1:0] A_WAIT  = 6'b110100;
    localparam logic [STATE_W-1:0] A_ERR   = 6'b001110;

    // Error code bit positions
    localparam int unsigned EB_MAIN = 0;
    localparam int unsigned EB_ACK  = 1;
    localparam int unsigned EB_CNT  = 2;

    function automatic logic main_legal(input logic [STATE_W-1:0] s);
        return (s == M_IDLE) || (s == M_RUN) || (s == M_DONE) || (s == M_ERR);
    endfunction

    function automatic logic ack_legal(input logic [STATE_W-1:0] s);
        return (s == A_IDLE) || (s == A_PULSE) || (s == A_WAIT) || (s == A_ERR);
    endfunction
endpackage

// File: rtl/hfsm_red_cnt.sv
// Module: redundant up-counter. The primary holds the value; the copy holds
// its bitwise complement and is updated with independent arithmetic.
// Assumes clr has priority over inc.
module hfsm_red_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             mismatch_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_cq;

    // Primary counter: clears to zero, counts up
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end

    // Complement copy: clears to all ones, counts down
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    cnt_cq <= '1;
        else if (clr_i) cnt_cq <= '1;
        else if (inc_i) cnt_cq <= cnt_cq - 1'b1;
    end

    // Continuous comparison of the pair
    always_comb begin
        mismatch_o = ~&(cnt_q ^ cnt_cq);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/hfsm_ack_fsm.sv
// Module: strobe handshake machine. Turns each rising strobe into one
// single-cycle step request. Sparse-encoded with its own legality check;
// falls into an absorbing error state on its own fault or on escalation.
module hfsm_ack_fsm
    import hfsm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    input  logic esc_i,
    output logic step_o,
    output logic illegal_o
);
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;

    // Legality check on every cycle
    always_comb begin
        illegal_o = !ack_legal(state_q);
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (illegal_o || esc_i) begin
            state_d = A_ERR;
        end else begin
            case (state_q)
                A_IDLE:  if (strobe_i) state_d = A_PULSE;
                A_PULSE: state_d = strobe_i ? A_WAIT : A_IDLE;
                A_WAIT:  if (!strobe_i) state_d = A_IDLE;
                default: state_d = A_ERR;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= A_IDLE;
        else         state_q <= state_d;
    end

    assign step_o = (state_q == A_PULSE);
endmodule

// File: rtl/hfsm_main_fsm.sv
// Module: main sequencing machine. Starts a run on a step request, counts
// steps against the target, reports done, and escalates any fault into an
// absorbing error state. Assumes target is stable during a run.
module hfsm_main_fsm
    import hfsm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] target_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             esc_i,
    output logic             cnt_clr_o,
    output logic             cnt_inc_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             in_err_o,
    output logic             illegal_o
);
    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;
    logic               last_step;
    logic               fault;

    // Legality check and combined fault
    always_comb begin
        illegal_o = !main_legal(state_q);
        fault     = illegal_o || esc_i;
    end

    // Detect that the step about to be taken reaches the target
    always_comb begin
        last_step = ({1'b0, cnt_i} + 1'b1) == {1'b0, target_i};
    end

    // Next state and counter controls
    always_comb begin
        state_d   = state_q;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        if (fault) begin
            state_d = M_ERR;
        end else begin
            case (state_q)
                M_IDLE: if (enable_i && step_i) begin
                    cnt_clr_o = 1'b1;
                    state_d   = (target_i == '0) ? M_DONE : M_RUN;
                end
                M_RUN: begin
                    if (!enable_i) begin
                        state_d = M_IDLE;
                    end else if (step_i) begin
                        cnt_inc_o = 1'b1;
                        if (last_step) state_d = M_DONE;
                    end
                end
                M_DONE: if (!enable_i || step_i) state_d = M_IDLE;
                M_ERR:  state_d = M_ERR;
                default: state_d = M_ERR;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= M_IDLE;
        else         state_q <= state_d;
    end

    assign busy_o   = (state_q == M_RUN);
    assign done_o   = (state_q == M_DONE);
    assign in_err_o = (state_q == M_ERR);
endmodule

// File: rtl/hfsm_ctrl.sv
// Module: top of the hardened controller. Wires the handshake machine, main
// machine and redundant counter, cross-escalates faults and keeps the
// sticky error code. Synchronous active-low reset throughout.
module hfsm_ctrl
    import hfsm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             strobe_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [ERR_W-1:0] err_code_o,
    output logic             fatal_alert_o
);
    logic             step;
    logic             ack_illegal;
    logic             main_illegal;
    logic             cnt_mismatch;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             main_in_err;
    logic [CNT_W-1:0] cnt;
    logic [ERR_W-1:0] fault_vec;
    logic [ERR_W-1:0] err_q;

    // Gather fault sources by error bit position
    always_comb begin
        fault_vec          = '0;
        fault_vec[EB_MAIN] = main_illegal;
        fault_vec[EB_ACK]  = ack_illegal;
        fault_vec[EB_CNT]  = cnt_mismatch;
    end

    hfsm_ack_fsm u_ack (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .strobe_i  (strobe_i),
        .esc_i     (main_illegal | cnt_mismatch),
        .step_o    (step),
        .illegal_o (ack_illegal)
    );

    hfsm_main_fsm #(.CNT_W(CNT_W)) u_main (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .enable_i  (enable_i),
        .step_i    (step),
        .target_i  (target_i),
        .cnt_i     (cnt),
        .esc_i     (ack_illegal | cnt_mismatch),
        .cnt_clr_o (cnt_clr),
        .cnt_inc_o (cnt_inc),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .in_err_o  (main_in_err),
        .illegal_o (main_illegal)
    );

    hfsm_red_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (cnt_clr),
        .inc_i      (cnt_inc),
        .cnt_o      (cnt),
        .mismatch_o (cnt_mismatch)
    );

    // One sticky flop per error bit
    for (genvar gi = 0; gi < ERR_W; gi++) begin : g_err
        always_ff @(posedge clk_i) begin
            if (!rst_ni)           err_q[gi] <= 1'b0;
            else if (fault_vec[gi]) err_q[gi] <= 1'b1;
        end
    end

    assign err_code_o    = err_q;
    assign fatal_alert_o = main_in_err;
endmodule

// File: rtl/hfsm_ctrl_chk.sv
// Checker: temporal properties of the controller's ports, bound to the top.
module hfsm_ctrl_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             enable_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [2:0]       err_code_o,
    input logic             fatal_alert_o
);
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(busy_o && done_o)); // R12
    AST_DISABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !enable_i |=> (!busy_o && !done_o)); // R5
    AST_ALERT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) fatal_alert_o |=> fatal_alert_o); // R10
    AST_ALERT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) fatal_alert_o |-> (!busy_o && !done_o)); // R10
    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) (err_code_o != 3'b000) |=> ((err_code_o & $past(err_code_o)) == $past(err_code_o))); // R11
    AST_ERR_ALERT: assert property (@(posedge clk_i) disable iff (!rst_ni) (err_code_o != 3'b000) |-> fatal_alert_o); // R11
    AST_CODE_ALERT_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(fatal_alert_o) |-> (err_code_o != 3'b000)); // R7
endmodule

bind hfsm_ctrl hfsm_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_code_o    (err_code_o),
    .fatal_alert_o (fatal_alert_o)
);

// File: tb/hfsm_ctrl_tb.sv
module hfsm_ctrl_tb;
    localparam int unsigned CNT_W  = 8;
    localparam time         CLK_PER = 10ns;

    logic             clk;
    logic             rst_n;
    logic             enable;
    logic             strobe;
    logic [CNT_W-1:0] target;
    logic             busy;
    logic             done;
    logic [2:0]       err_code;
    logic             alert;

    int n_checks;
    int n_fail;

    // Model state: 0 idle, 1 run, 2 done
    int m_state;
    int m_cnt;

    hfsm_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .enable_i      (enable),
        .strobe_i      (strobe),
        .target_i      (target),
        .busy_o        (busy),
        .done_o        (done),
        .err_code_o    (err_code),
        .fatal_alert_o (alert)
    );

    initial clk = 1'b0;
    always #(CLK_PER/2) clk = ~clk;

    function automatic logic exp_busy(input int st);
        return st == 1;
    endfunction

    function automatic logic exp_done(input int st);
        return st == 2;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input int st, input logic [2:0] ec, input logic al);
        check(req, {4'b0, busy, done, 1'b0, alert}, {4'b0, exp_busy(st), exp_done(st), 1'b0, al});
        check(req, {5'b0, err_code}, {5'b0, ec});
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        enable = 1'b0;
        strobe = 1'b0;
        target = '0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        m_state = 0;
        m_cnt   = 0;
    endtask

    // Strobe one cycle; returns after the main machine has acted
    task automatic pulse();
        @(negedge clk) strobe = 1'b1;
        @(negedge clk) strobe = 1'b0;
        @(negedge clk);
    endtask

    // Model of one step request
    task automatic model_step();
        if (!enable) return;
        case (m_state)
            0: begin m_cnt = 0; m_state = (target == 0) ? 2 : 1; end
            1: begin m_cnt++; if (m_cnt == int'(target)) m_state = 2; end
            default: m_state = 0;
        endcase
    endtask

    task automatic set_enable(input logic v);
        @(negedge clk) enable = v;
        @(negedge clk);
        if (!v) m_state = 0;
    endtask

    initial begin : watchdog
        #(CLK_PER * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main_seq
        n_checks = 0;
        n_fail   = 0;
        void'($urandom(32'd4242));
        do_reset();
        @(negedge clk);
        check_outs("R1 reset", 0, 3'b000, 1'b0);

        // R6: strobes ignored while disabled
        target = 8'd2;
        pulse(); pulse();
        check_outs("R6 disabled idle", 0, 3'b000, 1'b0);

        // R2: zero target finishes at start
        set_enable(1'b1);
        target = 8'd0;
        pulse(); model_step();
        check_outs("R2 zero target", m_state, 3'b000, 1'b0);
        pulse(); model_step();
        check_outs("R5 done strobe to idle", m_state, 3'b000, 1'b0);

        // R3: three steps
        target = 8'd3;
        pulse(); model_step();
        check_outs("R2 start busy", m_state, 3'b000, 1'b0);
        for (int i = 0; i < 3; i++) begin
            pulse(); model_step();
            check_outs("R3 step count", m_state, 3'b000, 1'b0);
        end
        check_outs("R3 reached done", 2, 3'b000, 1'b0);
        pulse(); model_step();

        // R4: held strobe is one step
        target = 8'd2;
        pulse(); model_step();
        @(negedge clk) strobe = 1'b1;
        repeat (10) @(negedge clk);
        strobe = 1'b0;
        @(negedge clk);
        model_step();
        check_outs("R4 held strobe single step", m_state, 3'b000, 1'b0);
        pulse(); model_step();
        check_outs("R4 second step done", 2, 3'b000, 1'b0);

        // R5: disable from run
        pulse(); model_step();
        target = 8'd4;
        pulse(); model_step();
        set_enable(1'b0);
        check_outs("R5 disable from run", 0, 3'b000, 1'b0);

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int act;
            act = int'($urandom_range(0, 9));
            if (act < 7) begin
                pulse(); model_step();
            end else if (act < 9) begin
                set_enable(~enable);
            end else if (m_state == 0) begin
                target = CNT_W'($urandom_range(0, 4));
            end
            check_outs("R3 random sequence", m_state, 3'b000, 1'b0);
        end

        // R7: illegal main state
        do_reset();
        @(negedge clk);
        force u_dut.u_main.state_q = 6'b000000;
        #1 release u_dut.u_main.state_q;
        @(negedge clk);
        check_outs("R7 main illegal", 0, 3'b001, 1'b1);
        enable = 1'b1; target = 8'd1;
        pulse(); pulse();
        check_outs("R10 absorbing after main fault", 0, 3'b001, 1'b1);
        set_enable(1'b0);
        check_outs("R11 sticky main bit", 0, 3'b001, 1'b1);

        // R8: illegal handshake state
        do_reset();
        @(negedge clk);
        force u_dut.u_ack.state_q = 6'b111111;
        #1 release u_dut.u_ack.state_q;
        @(negedge clk);
        check_outs("R8 ack illegal", 0, 3'b010, 1'b1);

        // R9: counter pair disagreement during a run
        do_reset();
        enable = 1'b1; target = 8'd5;
        pulse(); model_step();
        check_outs("R9 precondition busy", 1, 3'b000, 1'b0);
        @(negedge clk);
        force u_dut.u_cnt.cnt_q = 8'h10;
        #1 release u_dut.u_cnt.cnt_q;
        @(negedge clk);
        check_outs("R9 counter mismatch", 0, 3'b100, 1'b1);
        repeat (6) pulse();
        check_outs("R10 absorbing after counter fault", 0, 3'b100, 1'b1);

        // R1: reset leaves error state
        do_reset();
        @(negedge clk);
        check_outs("R1 reset clears error", 0, 3'b000, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule